// File: doc/BRIEF.md
# Delta Quiescent-Current Screening Unit

This unit sequences the current measurement for each test vector applied to a device under test and decides pass or fail from the result. When the tester applies a vector it pulses a strobe. The unit then counts down a programmable settling interval so that switching transients can die out. After that it requests one digitised supply-current sample from an external converter. Each accepted sample is compared with the sample taken for the previous vector. If the magnitude of that change exceeds a programmable decision limit, the vector fails. A raw-current ceiling can also be enabled, and any single sample above it marks the device defective.

The sample input is a valid/ready stream with one word per vector. `smp_req_o` acts as ready. It is high only after settling and stays high until one sample is taken. The converter may raise `smp_valid_i` early or late, and it must hold `smp_data_i` stable while `smp_valid_i` is high and `smp_req_o` is low. A word transfers on a clock edge where both are high, and no more than one word is taken per vector. Control and status pins are plain levels or pulses. A test-start pulse opens a new run. The fail flag stays set until the next start pulse, and the index of the first failing vector is kept.

Top module: `dq_screen`

## Requirements
- R1: After reset, `smp_req_o`, `busy_o`, `res_valid_o`, `fail_o` and `proto_err_o` are 0, `first_fail_idx_o` is 0, and the next accepted sample is treated as the first of a run.
- R2: A strobe on `vec_applied_i` while idle captures `settle_cycles_i` = N. `smp_req_o` rises exactly N+1 clock edges after the edge that sampled the strobe, and `busy_o` is high from the edge after the strobe until the sample is accepted.
- R3: A sample is taken only on an edge where `smp_valid_i` and `smp_req_o` are both high. `smp_valid_i` while `smp_req_o` is low consumes nothing. `smp_req_o` stays high until a transfer and falls on the edge that takes it.
- R4: The first sample after reset or a start pulse gets no difference check, only the raw-current check. It becomes the reference for the next vector.
- R5: Every later sample forms a 17-bit signed difference, current sample minus reference. Its magnitude is compared against the 16-bit `delta_limit_i`. It fails only when the magnitude is strictly greater, and increases and decreases are treated the same way. Each accepted sample becomes the new reference.
- R6: With `abs_check_en_i` = 1, a sample strictly greater than `abs_limit_i` fails the raw check. With it at 0, the raw check never fails.
- R7: `res_valid_o` pulses for one cycle on the edge after each transfer. `res_delta_fail_o` and `res_abs_fail_o` give that vector's two verdicts, and they have meaning only during the pulse.
- R8: `fail_o` sets on the first vector with either verdict failing and then stays set. `first_fail_idx_o` latches that vector's 0-based position within the run and ignores later failures.
- R9: A strobe that arrives while not idle sets `proto_err_o`, which stays set until a start pulse. The strobe is otherwise ignored: the running countdown and the pending request are unaffected.
- R10: `start_i` takes priority over every other input. On the next edge it clears `fail_o`, `proto_err_o`, `first_fail_idx_o` and the vector count, aborts any pending vector, and makes the next sample a first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Test-run start pulse |
| vec_applied_i | input | 1 | Vector-applied strobe |
| settle_cycles_i | input | 24 | Settling interval in clock cycles |
| delta_limit_i | input | 16 | Decision limit on the magnitude of the vector-to-vector change |
| abs_limit_i | input | 16 | Raw-current ceiling |
| abs_check_en_i | input | 1 | Enables the raw-current check |
| smp_valid_i | input | 1 | Converter sample valid |
| smp_data_i | input | 16 | Unsigned current sample |
| smp_req_o | output | 1 | Sample request (stream ready) |
| busy_o | output | 1 | A vector is settling or awaiting its sample |
| res_valid_o | output | 1 | Per-vector result pulse |
| res_delta_fail_o | output | 1 | Difference verdict of that vector |
| res_abs_fail_o | output | 1 | Raw-current verdict of that vector |
| fail_o | output | 1 | Sticky device-fail flag |
| first_fail_idx_o | output | 16 | Index of the first failing vector |
| proto_err_o | output | 1 | Sticky strobe-while-busy flag |

## Verification
The bench aims at the exact request latency for settle values of 0 and above. A countdown that is off by one would raise `smp_req_o` one edge early or late. A difference exactly equal to the limit must pass, and a downward step one count past it must fail. A comparison that is non-strict or one-sided would flip those verdicts. The bench holds valid high before the request to confirm nothing transfers early. It sends stray strobes mid-countdown, which must not restart the timer. It checks that a later failure leaves the first-fail index alone. It also checks that after a start pulse the first sample is judged only against the raw ceiling, even when it differs greatly from the stale reference.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } dq_state_e;

  typedef struct packed {
    logic delta_fail;
    logic abs_fail;
  } dq_verdict_t;
endpackage

// File: rtl/dq_settle_timer.sv
module dq_settle_timer
  import dq_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vec_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             accept_i,
  output dq_state_e        state_o,
  output logic             req_o,
  output logic             stray_o
);
  dq_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (vec_i) begin
          cnt_q   <= settle_i;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (cnt_q == '0) state_q <= ST_SAMPLE;
                   else cnt_q <= cnt_q - 1'b1;
        ST_SAMPLE: if (accept_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign req_o   = (state_q == ST_SAMPLE);
  assign stray_o = vec_i && (state_q != ST_IDLE) && !start_i;

  // R3: request holds until a transfer
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !accept_i && !start_i) |=> req_o);
  // R9: a stray strobe during settling never drops the unit back to idle
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stray_o && state_q == ST_SETTLE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/dq_delta_judge.sv
module dq_delta_judge
  import dq_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic [SMP_W-1:0] sample_i,
  input  logic [SMP_W-1:0] ref_i,
  input  logic             first_i,
  input  logic [SMP_W-1:0] delta_lim_i,
  input  logic [SMP_W-1:0] abs_lim_i,
  input  logic             abs_en_i,
  output dq_verdict_t      verdict_o
);
  localparam int DW = SMP_W + 1;

  logic signed [DW-1:0] diff;
  logic        [DW-1:0] mag;

  always_comb begin
    diff = $signed({1'b0, sample_i}) - $signed({1'b0, ref_i});
    mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
    verdict_o.delta_fail = !first_i && (mag > {1'b0, delta_lim_i});
    verdict_o.abs_fail   = abs_en_i && (sample_i > abs_lim_i);
  end
endmodule

// File: rtl/dq_run_tracker.sv
module dq_run_tracker
  import dq_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic             stray_i,
  input  logic [SMP_W-1:0] sample_i,
  input  dq_verdict_t      verdict_i,
  output logic [SMP_W-1:0] ref_o,
  output logic             first_o,
  output logic             res_valid_o,
  output dq_verdict_t      res_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] first_idx_o,
  output logic             perr_o
);
  logic [IDX_W-1:0] idx_q;
  logic             any_fail;

  assign any_fail = verdict_i.delta_fail || verdict_i.abs_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_o       <= '0;
      first_o     <= 1'b1;
      res_valid_o <= 1'b0;
      res_o       <= '0;
      fail_o      <= 1'b0;
      first_idx_o <= '0;
      perr_o      <= 1'b0;
      idx_q       <= '0;
    end else if (start_i) begin
      first_o     <= 1'b1;
      res_valid_o <= 1'b0;
      fail_o      <= 1'b0;
      first_idx_o <= '0;
      perr_o      <= 1'b0;
      idx_q       <= '0;
    end else begin
      res_valid_o <= accept_i;
      if (accept_i) begin
        res_o   <= verdict_i;
        ref_o   <= sample_i;
        first_o <= 1'b0;
        idx_q   <= idx_q + 1'b1;
        if (any_fail && !fail_o) begin
          fail_o      <= 1'b1;
          first_idx_o <= idx_q;
        end
      end
      if (stray_i) perr_o <= 1'b1;
    end
  end

  // R8: fail flag and first index hold until a start pulse
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);
  p_idx_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> $stable(first_idx_o));
  // R9: protocol error is sticky
  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_o && !start_i) |=> perr_o);
  // R10: start clears the status
  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!fail_o && !perr_o && !res_valid_o));
endmodule

// File: rtl/dq_screen.sv
module dq_screen
  import dq_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int CNT_W = 24,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vec_applied_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  input  logic [SMP_W-1:0] delta_limit_i,
  input  logic [SMP_W-1:0] abs_limit_i,
  input  logic             abs_check_en_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             smp_req_o,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic             res_delta_fail_o,
  output logic             res_abs_fail_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] first_fail_idx_o,
  output logic             proto_err_o
);
  dq_state_e        state;
  logic             req, stray, accept, first;
  logic [SMP_W-1:0] ref_smp;
  dq_verdict_t      verdict, res;

  assign accept = smp_valid_i && req;

  dq_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_applied_i),
    .settle_i(settle_cycles_i), .accept_i(accept),
    .state_o(state), .req_o(req), .stray_o(stray)
  );

  dq_delta_judge #(.SMP_W(SMP_W)) u_judge (
    .sample_i(smp_data_i), .ref_i(ref_smp), .first_i(first),
    .delta_lim_i(delta_limit_i), .abs_lim_i(abs_limit_i),
    .abs_en_i(abs_check_en_i), .verdict_o(verdict)
  );

  dq_run_tracker #(.SMP_W(SMP_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_i(accept),
    .stray_i(stray), .sample_i(smp_data_i), .verdict_i(verdict),
    .ref_o(ref_smp), .first_o(first), .res_valid_o(res_valid_o),
    .res_o(res), .fail_o(fail_o), .first_idx_o(first_fail_idx_o),
    .perr_o(proto_err_o)
  );

  assign smp_req_o        = req;
  assign busy_o           = (state != ST_IDLE);
  assign res_delta_fail_o = res.delta_fail;
  assign res_abs_fail_o   = res.abs_fail;

  // R7: every result pulse follows a transfer
  p_result_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(smp_valid_i && smp_req_o));
  // R4: the first result of a run never carries a difference failure
  p_first_no_delta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first && !start_i) |=> !res_delta_fail_o);
endmodule

// File: tb/test_dq_screen.sv
module test_dq_screen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, vec_applied_i = 1'b0;
  logic [23:0] settle_cycles_i = '0;
  logic [15:0] delta_limit_i = 16'd100, abs_limit_i = 16'd5000;
  logic        abs_check_en_i = 1'b1;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic        smp_req_o, busy_o, res_valid_o, res_delta_fail_o, res_abs_fail_o;
  logic        fail_o, proto_err_o;
  logic [15:0] first_fail_idx_o;

  int checks = 0, fails = 0;
  bit done = 0, model_on = 0;

  always #4 clk = ~clk;

  dq_screen i_dq_screen (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_st = 0, m_cnt = 0, m_ref = 0, m_idx = 0, m_fidx = 0;
  bit m_first = 1, m_fail = 0, m_perr = 0, m_rv = 0, m_rd = 0, m_ra = 0;

  always @(posedge clk) begin
    bit acc, stray, df, af;
    int d;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ref = 0; m_idx = 0; m_fidx = 0;
      m_first = 1; m_fail = 0; m_perr = 0; m_rv = 0; m_rd = 0; m_ra = 0;
    end else if (start_i) begin
      m_st = 0; m_cnt = 0; m_idx = 0; m_fidx = 0;
      m_first = 1; m_fail = 0; m_perr = 0; m_rv = 0;
    end else begin
      acc   = smp_valid_i && (m_st == 2);
      stray = vec_applied_i && (m_st != 0);
      m_rv  = acc;
      if (acc) begin
        d  = int'(smp_data_i) - m_ref;
        if (d < 0) d = -d;
        df = !m_first && (d > int'(delta_limit_i));
        af = abs_check_en_i && (smp_data_i > abs_limit_i);
        m_rd = df; m_ra = af;
        m_ref = int'(smp_data_i); m_first = 0;
        if ((df || af) && !m_fail) begin m_fail = 1; m_fidx = m_idx; end
        m_idx = (m_idx + 1) % 65536;
      end
      if (stray) m_perr = 1;
      case (m_st)
        0: if (vec_applied_i) begin m_cnt = int'(settle_cycles_i); m_st = 1; end
        1: if (m_cnt == 0) m_st = 2; else m_cnt--;
        2: if (acc) m_st = 0;
        default: m_st = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #2;
    if (model_on) begin
      chk(smp_req_o == (m_st == 2), "R2 smp_req_o", smp_req_o, m_st == 2);
      chk(busy_o == (m_st != 0), "R2 busy_o", busy_o, m_st != 0);
      chk(res_valid_o == m_rv, "R7 res_valid_o", res_valid_o, m_rv);
      if (m_rv) begin
        chk(res_delta_fail_o == m_rd, "R5 res_delta_fail_o", res_delta_fail_o, m_rd);
        chk(res_abs_fail_o == m_ra, "R6 res_abs_fail_o", res_abs_fail_o, m_ra);
      end
      chk(fail_o == m_fail, "R8 fail_o", fail_o, m_fail);
      chk(int'(first_fail_idx_o) == m_fidx, "R8 first_fail_idx_o", first_fail_idx_o, m_fidx);
      chk(proto_err_o == m_perr, "R9 proto_err_o", proto_err_o, m_perr);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic strobe(input int n);
    @(negedge clk) begin vec_applied_i = 1'b1; settle_cycles_i = 24'(n); end
    @(negedge clk) vec_applied_i = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!smp_req_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic give(input int data, input int delay);
    repeat (delay) @(negedge clk);
    smp_valid_i = 1'b1; smp_data_i = 16'(data);
    @(negedge clk) smp_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic vector(input int settle, input int data, input int delay);
    int n;
    strobe(settle);
    wait_req(n);
    chk(n == settle + 1, "R2 request latency", n, settle + 1);
    give(data, delay);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(smp_req_o == 0, "R1 req after reset", smp_req_o, 0);
    chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
    chk(fail_o == 0 && proto_err_o == 0, "R1 flags after reset", fail_o | proto_err_o, 0);
    chk(first_fail_idx_o == 0, "R1 index after reset", first_fail_idx_o, 0);
    rst_n = 1'b1; model_on = 1;
    pulse_start();

    vector(3, 1000, 0);                       // R4 first vector
    vector(0, 1100, 2);                       // R5 diff == limit passes
    chk(fail_o == 0, "R5 equal limit passes", fail_o, 0);
    vector(5, 999, 1);                        // R5 diff -101 fails
    chk(fail_o == 1, "R5 downward step fails", fail_o, 1);
    chk(first_fail_idx_o == 2, "R8 first index", first_fail_idx_o, 2);
    vector(2, 1500, 0);                       // R8 later fail
    chk(first_fail_idx_o == 2, "R8 index held", first_fail_idx_o, 2);

    // R9 stray strobe during settling
    strobe(5);
    @(negedge clk) vec_applied_i = 1'b1;
    @(negedge clk) vec_applied_i = 1'b0;
    wait_req(n);
    chk(n + 2 == 6, "R9 timer not restarted", n + 2, 6);
    chk(proto_err_o == 1, "R9 proto_err set", proto_err_o, 1);
    give(1520, 0);

    // R3 valid held before request
    strobe(4);
    smp_valid_i = 1'b1; smp_data_i = 16'd1530;
    repeat (2) @(negedge clk);
    chk(res_valid_o == 0 && busy_o == 1, "R3 no early transfer", res_valid_o, 0);
    wait_req(n);
    @(negedge clk) smp_valid_i = 1'b0;
    chk(smp_req_o == 0, "R3 request drops after transfer", smp_req_o, 0);
    @(negedge clk);

    // R10 new run, R4 first sample against stale reference, R6 raw ceiling
    pulse_start();
    chk(fail_o == 0 && proto_err_o == 0, "R10 start clears", fail_o | proto_err_o, 0);
    vector(1, 60000, 0);
    chk(fail_o == 1, "R6 raw ceiling fails", fail_o, 1);
    chk(first_fail_idx_o == 0, "R4 first vector index", first_fail_idx_o, 0);
    abs_check_en_i = 1'b0;
    vector(2, 60050, 0);                      // R6 disabled, delta 50 passes

    // R10 abort mid-settle
    strobe(10);
    repeat (3) @(negedge clk);
    pulse_start();
    chk(busy_o == 0, "R10 abort pending vector", busy_o, 0);
    chk(fail_o == 0, "R10 fail cleared", fail_o, 0);
    delta_limit_i = 16'd10;
    vector(0, 100, 0);                        // R4 no delta vs stale 60050
    chk(fail_o == 0, "R4 first after start not differenced", fail_o, 0);
    vector(0, 111, 0);                        // R5 upward step of 11 > 10
    chk(fail_o == 1, "R5 upward step fails", fail_o, 1);
    chk(first_fail_idx_o == 1, "R8 index in new run", first_fail_idx_o, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule